// File: doc/BRIEF.md
# Scrambled RAM Access Sequencer

This block turns a stream of single-word read and write requests into accesses on a one-port RAM whose contents are encrypted. Each stored word holds 39 bits: a 32-bit data part and 7 check bits. The whole word is XORed with a keystream. The keystream comes from a two-stage pipelined mixing function of a 64-bit key, a 32-bit nonce and the word address.

A read returns its data one cycle after it is accepted. A full-word write shares the keystream pipeline with reads, so it is committed one cycle late. When a read claims the RAM port in that cycle, the encrypted word waits in a holding register. It is written on the first cycle the port is free, and any read of that address is served from the plain copy held beside it. A store that enables only some bytes runs as read, merge and rewrite, and the check bits are recomputed over the merged word.

An external integrity-fault flag inverts the nonce and blocks every RAM access while it is high. The request port uses valid/ready. A request is taken on a rising edge where both are high. The request fields must stay stable while valid is high and ready is low. Ready depends only on internal state, never on valid. The response port has no back-pressure: the user must take each response in the cycle it is shown.

Top module: `scr_ram_seq`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: A read accepted on an edge gives `rsp_valid_o`=1 for exactly the following cycle. `rsp_rdata_o` then holds the data of the most recent write to that address.
- R3: Full-word writes (`req_be_i`=4'b1111) and reads are accepted back to back. A strictly alternating write/read stream keeps `req_ready_o` high on every cycle.
- R4: A read accepted on the edge right after a write to the same address returns the new write data, even though the RAM does not hold it yet.
- R5: While a write waits in the holding register, reads keep going at full rate and read their own addresses correctly. The waiting write reaches the RAM and is visible to all later reads.
- R6: A write with `req_be_i` not all ones updates only the enabled bytes. Bit b of `req_be_i` enables data bits 8b+7 down to 8b. `req_ready_o` is 0 for the two cycles after such a write is accepted, so the write occupies three cycles.
- R7: A partial write accepted right after a full write to the same address merges into the newly written data.
- R8: A read ignores `req_be_i`. It returns the full 32-bit word with the same one-cycle latency.
- R9: Check bit i, for i from 0 to 5, is the XOR of the data bits j for which bit i of j+1 is set. Check bit 6 is the XOR of all data bits and check bits 0 to 5. The check bits are stored with each word. `rsp_integ_err_o` is 1 on a response whose stored check bits disagree with its data, so it is 0 for every word this block wrote.
- R10: While `integ_err_i` is 1, no RAM access takes place. Accepted reads respond with all-zero data, and accepted writes leave the RAM unchanged. After the flag drops, earlier contents read back intact.
- R11: An accepted write produces no response: `rsp_valid_o` stays 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| key_i | input | 64 | Scrambling key, held stable during use |
| nonce_i | input | 32 | Scrambling nonce, held stable during use |
| integ_err_i | input | 1 | Latched integrity fault: inverts the nonce and blocks RAM access |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_be_i | input | 4 | Byte enables for writes |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_rdata_o | output | 32 | Read data |
| rsp_integ_err_o | output | 1 | Stored check bits mismatch on this response |

## Verification
The bench targets the cycle after a write, where a same-address read must be forwarded. A design without forwarding would return stale RAM contents there. It also runs read bursts while a write is held, where a dropped or overwritten held word would show up as wrong data on a later read. Partial writes are checked for correct merging, including a merge against a write that has not yet been committed, and for exactly two stall cycles. A missing stall or a wrong merge source would corrupt the bytes that were not enabled, and a mistake in the check bits would raise the integrity flag. The fault sequence checks that a write issued during the fault leaves the old word intact.

// File: rtl/scr_ram_pkg.sv
package scr_ram_pkg;
  localparam int DATA_W  = 32;
  localparam int CHK_W   = 7;
  localparam int WORD_W  = DATA_W + CHK_W;
  localparam int KEY_W   = 64;
  localparam int NONCE_W = 32;
  localparam int BYTES   = DATA_W / 8;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_MERGE = 2'd2
  } op_e;

  // SEC-DED style check bits over one data word
  function automatic logic [CHK_W-1:0] chk_bits(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    c = '0;
    for (int i = 0; i < CHK_W - 1; i++) begin
      for (int j = 0; j < DATA_W; j++) begin
        if (((j + 1) >> i) % 2 == 1) c[i] = c[i] ^ d[j];
      end
    end
    c[CHK_W-1] = ^{d, c[CHK_W-2:0]};
    return c;
  endfunction

  // First half of the keyed mixing stand-in
  function automatic logic [63:0] mix_a(input logic [KEY_W-1:0] k,
                                        input logic [NONCE_W-1:0] n,
                                        input logic [31:0] a);
    logic [31:0] t, lo, hi;
    t  = n ^ (a * 32'h9E3779B1);
    lo = k[31:0] ^ t;
    hi = k[63:32] ^ {t[18:0], t[31:19]};
    return {hi + lo, lo ^ {hi[7:0], hi[31:8]}};
  endfunction

  // Second half: expand to a full word of keystream
  function automatic logic [WORD_W-1:0] mix_b(input logic [63:0] m);
    logic [31:0] s;
    s = m[63:32] ^ (m[31:0] + {m[50:32], m[63:51]});
    return {m[6:0] ^ m[38:32], s};
  endfunction
endpackage

// File: rtl/scr_ks_pipe.sv
module scr_ks_pipe
  import scr_ram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [NONCE_W-1:0] nonce_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [WORD_W-1:0]  ks_o
);
  logic [63:0] mid_q;
  logic [31:0] addr_ext;

  assign addr_ext = 32'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mid_q <= '0;
    else if (load_i) mid_q <= mix_a(key_i, nonce_i, addr_ext);
  end

  assign ks_o = mix_b(mid_q);
endmodule

// File: rtl/scr_ram_mem.sv
module scr_ram_mem #(
  parameter int ADDR_W = 8,
  parameter int WIDTH  = 39
) (
  input  logic              clk_i,
  input  logic              re_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/scr_ram_seq.sv
module scr_ram_seq
  import scr_ram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [NONCE_W-1:0] nonce_i,
  input  logic               integ_err_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [BYTES-1:0]   req_be_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_rdata_o,
  output logic               rsp_integ_err_o
);
  // request acceptance
  logic acc, full_be, rd_port, acc_merge;
  logic [NONCE_W-1:0] nonce_eff;

  // stage after acceptance
  logic               s1_v, s1_blk;
  op_e                s1_op;
  logic [ADDR_W-1:0]  s1_addr;
  logic [DATA_W-1:0]  s1_wdata;
  logic [BYTES-1:0]   s1_be;

  // merged write-back stage
  logic              wb_v;
  logic [ADDR_W-1:0] wb_addr;
  logic [DATA_W-1:0] wb_data;

  // holding registers: plain copy for forwarding, encrypted copy for commit
  logic              hold_v;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic [WORD_W-1:0] hold_scr;

  logic [WORD_W-1:0] ks, ram_q, ram_plain, ram_wdata, cm_scr;
  logic [ADDR_W-1:0] ram_addr, cm_addr;
  logic [DATA_W-1:0] old_data, merged, cm_data;
  logic              fwd, chk_bad, cm_v, drain, direct, ram_we;

  assign full_be   = &req_be_i;
  assign acc       = req_valid_i & req_ready_o;
  assign rd_port   = acc & (~req_write_i | ~full_be) & ~integ_err_i;
  assign acc_merge = acc & req_write_i & ~full_be & ~integ_err_i;
  assign nonce_eff = integ_err_i ? ~nonce_i : nonce_i;

  assign req_ready_o = ~(s1_v & (s1_op == OP_MERGE)) & ~wb_v &
                       ~(hold_v & s1_v & (s1_op == OP_WRITE));

  scr_ks_pipe #(.ADDR_W(ADDR_W)) u_ks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (acc),
    .key_i   (key_i),
    .nonce_i (nonce_eff),
    .addr_i  (req_addr_i),
    .ks_o    (ks)
  );

  scr_ram_mem #(.ADDR_W(ADDR_W), .WIDTH(WORD_W)) u_mem (
    .clk_i   (clk_i),
    .re_i    (rd_port),
    .we_i    (ram_we),
    .addr_i  (ram_addr),
    .wdata_i (ram_wdata),
    .rdata_o (ram_q)
  );

  // old word: forwarded from the plain holding copy, else decrypted RAM data
  assign ram_plain = ram_q ^ ks;
  assign fwd       = hold_v & (hold_addr == s1_addr);
  assign old_data  = fwd ? hold_data : ram_plain[DATA_W-1:0];
  assign chk_bad   = ~fwd & (ram_plain[WORD_W-1:DATA_W] != chk_bits(ram_plain[DATA_W-1:0]));

  assign rsp_valid_o     = s1_v & (s1_op == OP_READ);
  assign rsp_rdata_o     = s1_blk ? '0 : old_data;
  assign rsp_integ_err_o = rsp_valid_o & ~s1_blk & chk_bad;

  always_comb begin
    for (int b = 0; b < BYTES; b++) begin
      merged[8*b +: 8] = s1_be[b] ? s1_wdata[8*b +: 8] : old_data[8*b +: 8];
    end
  end

  // commit of a full write (stage 1) or a merged write (write-back stage)
  assign cm_v    = ((s1_v & (s1_op == OP_WRITE) & ~s1_blk) | wb_v) & ~integ_err_i;
  assign cm_addr = wb_v ? wb_addr : s1_addr;
  assign cm_data = wb_v ? wb_data : s1_wdata;
  assign cm_scr  = {chk_bits(cm_data), cm_data} ^ ks;

  assign drain     = hold_v & ~rd_port & ~integ_err_i;
  assign direct    = cm_v & ~rd_port & ~hold_v;
  assign ram_we    = drain | direct;
  assign ram_wdata = drain ? hold_scr : cm_scr;
  assign ram_addr  = rd_port ? req_addr_i : (drain ? hold_addr : cm_addr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v      <= 1'b0;
      s1_blk    <= 1'b0;
      s1_op     <= OP_READ;
      s1_addr   <= '0;
      s1_wdata  <= '0;
      s1_be     <= '0;
      wb_v      <= 1'b0;
      wb_addr   <= '0;
      wb_data   <= '0;
      hold_v    <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
      hold_scr  <= '0;
    end else begin
      s1_v <= acc;
      if (acc) begin
        s1_blk   <= integ_err_i;
        s1_op    <= !req_write_i ? OP_READ : (full_be ? OP_WRITE : OP_MERGE);
        s1_addr  <= req_addr_i;
        s1_wdata <= req_wdata_i;
        s1_be    <= req_be_i;
      end
      wb_v <= s1_v & (s1_op == OP_MERGE) & ~s1_blk & ~integ_err_i;
      if (s1_v & (s1_op == OP_MERGE)) begin
        wb_addr <= s1_addr;
        wb_data <= merged;
      end
      if (cm_v & ~direct) begin
        hold_v    <= 1'b1;
        hold_addr <= cm_addr;
        hold_data <= cm_data;
        hold_scr  <= cm_scr;
      end else if (drain) begin
        hold_v <= 1'b0;
      end
    end
  end

  // R5: the holding register never has to take a word while it is full and the port is busy
  p_hold_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_v & rd_port) |-> !cm_v);

  // R2: an accepted read is answered in the next cycle
  p_read_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc & !req_write_i) |=> rsp_valid_o);

  // R11: writes give no response
  p_write_silent_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc & req_write_i) |=> !rsp_valid_o);

  // R6: partial write holds off the request port for two cycles
  p_merge_stall_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_merge |=> !req_ready_o);
  p_merge_stall_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_merge |=> ##1 !req_ready_o);

  // R10: no RAM activity while the fault flag is high
  p_fault_blocks_ram_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    integ_err_i |-> !(ram_we | rd_port));
endmodule

// File: tb/sim_scr_ram_seq.sv
`timescale 1ns/1ps
module sim_scr_ram_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] key = 64'h0123_4567_89AB_CDEF;
  logic [31:0] nonce = 32'h5A5A_1234;
  logic        ierr = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [3:0]  req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_ierr;
  logic [31:0] rsp_rdata;

  int n_chk = 0, n_fail = 0, stalls = 0, tot_stalls = 0;

  always #10 clk = ~clk;

  scr_ram_seq #(.ADDR_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .key_i(key), .nonce_i(nonce), .integ_err_i(ierr),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_integ_err_o(rsp_ierr)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [3:0]  be;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VT [NV] = '{
    '{1'b1, 8'h10, 4'hF, 32'h11223344, 32'h0},        // full write
    '{1'b0, 8'h10, 4'hF, 32'h0, 32'h11223344},        // R4 forwarded read
    '{1'b1, 8'h11, 4'hF, 32'hA5A5A5A5, 32'h0},
    '{1'b0, 8'h10, 4'hF, 32'h0, 32'h11223344},        // R5 read from RAM while 0x11 held
    '{1'b0, 8'h11, 4'hF, 32'h0, 32'hA5A5A5A5},        // R5 second read, held word forwarded
    '{1'b1, 8'h10, 4'b0010, 32'h0000BB00, 32'h0},     // R6 byte 1 only
    '{1'b0, 8'h10, 4'hF, 32'h0, 32'h1122BB44},
    '{1'b1, 8'h12, 4'hF, 32'hDEADBEEF, 32'h0},
    '{1'b1, 8'h13, 4'hF, 32'h0BADF00D, 32'h0},
    '{1'b0, 8'h12, 4'hF, 32'h0, 32'hDEADBEEF},
    '{1'b0, 8'h13, 4'hF, 32'h0, 32'h0BADF00D},
    '{1'b1, 8'h11, 4'b1001, 32'h77000088, 32'h0},     // R6 bytes 3 and 0
    '{1'b0, 8'h11, 4'hF, 32'h0, 32'h77A5A588},
    '{1'b0, 8'h10, 4'b0001, 32'h0, 32'h1122BB44},     // R8 enables ignored on read
    '{1'b1, 8'h20, 4'hF, 32'h00000000, 32'h0},
    '{1'b0, 8'h20, 4'hF, 32'h0, 32'h00000000},
    '{1'b1, 8'h20, 4'hF, 32'hFFFFFFFF, 32'h0},
    '{1'b0, 8'h20, 4'hF, 32'h0, 32'hFFFFFFFF},
    '{1'b1, 8'h30, 4'hF, 32'h12345678, 32'h0},
    '{1'b1, 8'h30, 4'b0100, 32'h00CC0000, 32'h0},     // R7 merge against uncommitted write
    '{1'b0, 8'h30, 4'hF, 32'h0, 32'h12CC5678}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic do_req(input logic w, input logic [7:0] a, input logic [3:0] be,
                        input logic [31:0] d, input logic [31:0] exp, input string tag);
    req_valid = 1'b1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
    stalls = 0;
    while (!req_ready) begin
      @(negedge clk);
      stalls++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    tot_stalls += stalls;
    if (!w) begin
      check(rsp_valid === 1'b1 && rsp_rdata === exp, tag, rsp_rdata, exp);
      check(rsp_ierr === 1'b0, "R9 check bits", {31'b0, rsp_ierr}, 32'h0);
    end else begin
      check(rsp_valid === 1'b0, "R11 write gives no response", {31'b0, rsp_valid}, 32'h0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 in reset",
          {30'b0, req_ready, rsp_valid}, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 after reset",
          {30'b0, req_ready, rsp_valid}, 32'h2);

    // vector table: R2 R4 R5 R6 R7 R8 data checks
    for (int i = 0; i < NV; i++) begin
      do_req(VT[i].wr, VT[i].a, VT[i].be, VT[i].d, VT[i].e, $sformatf("R2 table vector %0d", i));
    end

    // R3: alternating full writes and reads never stall
    tot_stalls = 0;
    for (int i = 0; i < 4; i++) begin
      do_req(1'b1, 8'h50 + 8'(i), 4'hF, 32'hC0DE0000 + i, 32'h0, "R3 write");
      do_req(1'b0, 8'h50 + 8'(i), 4'hF, 32'h0, 32'hC0DE0000 + i, "R3 read");
    end
    check(tot_stalls == 0, "R3 stall count", tot_stalls, 0);

    // R5: burst of reads while a write is held, then the held word is read back later
    do_req(1'b1, 8'h60, 4'hF, 32'h600DF00D, 32'h0, "R5 write");
    do_req(1'b0, 8'h12, 4'hF, 32'h0, 32'hDEADBEEF, "R5 burst read a");
    do_req(1'b0, 8'h13, 4'hF, 32'h0, 32'h0BADF00D, "R5 burst read b");
    do_req(1'b0, 8'h60, 4'hF, 32'h0, 32'h600DF00D, "R5 burst read c");
    repeat (2) @(negedge clk);
    do_req(1'b0, 8'h60, 4'hF, 32'h0, 32'h600DF00D, "R5 after commit");

    // R6: partial write occupies three cycles
    do_req(1'b1, 8'h61, 4'hF, 32'h00000000, 32'h0, "R6 base write");
    do_req(1'b1, 8'h61, 4'b0001, 32'h000000AA, 32'h0, "R6 partial write");
    do_req(1'b0, 8'h61, 4'hF, 32'h0, 32'h000000AA, "R6 merged value");
    check(stalls == 2, "R6 stall cycles", stalls, 2);

    // R10: fault flag blocks RAM access, old contents survive
    do_req(1'b1, 8'h40, 4'hF, 32'hCAFEF00D, 32'h0, "R10 setup write");
    do_req(1'b0, 8'h40, 4'hF, 32'h0, 32'hCAFEF00D, "R10 setup read");
    repeat (2) @(negedge clk);
    ierr = 1'b1;
    do_req(1'b1, 8'h40, 4'hF, 32'h00000000, 32'h0, "R10 blocked write");
    do_req(1'b0, 8'h40, 4'hF, 32'h0, 32'h00000000, "R10 blocked read zero");
    repeat (2) @(negedge clk);
    ierr = 1'b0;
    repeat (2) @(negedge clk);
    do_req(1'b0, 8'h40, 4'hF, 32'h0, 32'hCAFEF00D, "R10 contents intact");

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule